// File: doc/BRIEF.md
# Transmit and Receive Word FIFO Pair with Occupancy Thresholds

This block sits between a register bus and a serial shifter and buffers data in both directions. The transmit FIFO takes words from the bus and hands transfer units to the shifter. The receive FIFO takes units from the shifter and hands them to the bus. Each FIFO stores bytes, eight by default. A unit is either one byte or four bytes, chosen by a mode bit. Bytes are packed into the 32-bit word little-endian: the first byte on the wire is in bits [7:0].

Each FIFO drives a full flag, an empty flag, a threshold ready flag and two sticky error flags, overflow and underflow. All of them appear at fixed positions in a status word. A configuration word holds the two 3-bit thresholds, the unit mode, a flush bit that clears itself, and a soft reset bit. The shifter and the interrupt logic sit outside this block.

Both data paths use valid/ready handshakes. A producer may hold valid high while ready is low, but such a beat is not stored: it is dropped and counted as an overflow. A consumer should raise ready only while valid is high. Ready raised while valid is low is treated as a pop from an empty FIFO, which sets underflow and changes nothing else.

Top module: `spi_word_fifo_pair`

## Requirements
- R1: After reset the configuration word reads 0. Both FIFOs are empty, and the status word is 0x058 (both empty bits set, transmit ready set).
- R2: In 4-byte mode a pushed word leaves the FIFO unchanged and in push order. Byte k of the word, bits [8k+7:8k], is byte k of the unit.
- R3: In 1-byte mode a push stores only bits [7:0]. The output word carries the oldest byte in bits [7:0], with bits [31:8] zero.
- R4: A FIFO is full when fewer than one unit of space is free (status bit 7 for transmit, bit 5 for receive). While it is full, its input ready is low.
- R5: A FIFO is empty when it holds less than one unit (status bit 6 for transmit, bit 4 for receive). While it is empty, its output valid is low.
- R6: A push while the FIFO is full is dropped. It sets the overflow flag, status bit 11 for transmit and bit 9 for receive, and the flag stays set.
- R7: A pop while the FIFO is empty is dropped. It sets the underflow flag, status bit 10 for transmit and bit 8 for receive, and the flag stays set.
- R8: A one on err_clr bit k clears status bit 8+k. A new error in the same cycle wins over the clear.
- R9: Transmit ready (status bit 3) is high while the transmit occupancy in bytes is at most the threshold in configuration bits [30:28].
- R10: Receive ready (status bit 2) is high while the receive occupancy in bytes exceeds the threshold in configuration bits [26:24].
- R11: Writing configuration bit 9 empties both FIFOs on the next clock. The bit reads back as 0 from then on, and data traffic in that cycle is ignored. The error flags are kept.
- R12: While configuration bit 16 is set, both FIFOs are held empty, all error flags are held clear, and traffic is ignored.
- R13: Configuration bit 5 selects 4-byte units when set and 1-byte units when clear. Only bits [30:28], [26:24], 16, 9 and 5 are stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration |
| err_clr | input | 4 | Clear strobes for status bits 11:8 |
| status | output | 12 | Flags; bits 1:0 read zero |
| bus_tx_valid | input | 1 | Bus offers a transmit word |
| bus_tx_ready | output | 1 | Transmit FIFO can take a unit |
| bus_tx_data | input | 32 | Transmit word |
| sh_tx_valid | output | 1 | Transmit unit available |
| sh_tx_ready | input | 1 | Shifter takes a transmit unit |
| sh_tx_data | output | 32 | Oldest transmit unit |
| sh_rx_valid | input | 1 | Shifter offers a receive unit |
| sh_rx_ready | output | 1 | Receive FIFO can take a unit |
| sh_rx_data | input | 32 | Receive unit |
| bus_rx_valid | output | 1 | Receive unit available |
| bus_rx_ready | input | 1 | Bus takes a receive unit |
| bus_rx_data | output | 32 | Oldest receive unit |

## Verification
All outputs come from registered state, so every effect of a handshake, error strobe or configuration write is visible one clock after the edge that samples it. The flush is the exception: it takes effect at the second edge after the write, when both FIFOs empty and the flush bit drops together. The bench drives inputs on the falling edge and updates its queue model on the rising edge. It compares every output on the following falling edge, a half period after the edge that changed it. The flush is checked on both falling edges, once with the bit still set and once with it clear.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
  localparam int WORD_W         = 32;
  localparam int UNIT_MAX       = WORD_W / 8;
  localparam int THR_W          = 3;
  localparam int CFG_TX_THR_LSB = 28;
  localparam int CFG_RX_THR_LSB = 24;
  localparam int CFG_SRST_BIT   = 16;
  localparam int CFG_FLUSH_BIT  = 9;
  localparam int CFG_UNIT4_BIT  = 5;
  localparam logic [WORD_W-1:0] CFG_MASK = 32'h7701_0220;

  localparam int ST_W        = 12;
  localparam int ST_RX_RDY   = 2;
  localparam int ST_TX_RDY   = 3;
  localparam int ST_RX_EMPTY = 4;
  localparam int ST_RX_FULL  = 5;
  localparam int ST_TX_EMPTY = 6;
  localparam int ST_TX_FULL  = 7;
  localparam int ST_RX_UDF   = 8;
  localparam int ST_RX_OVF   = 9;
  localparam int ST_TX_UDF   = 10;
  localparam int ST_TX_OVF   = 11;

  typedef struct packed {
    logic [THR_W-1:0] tx_thr;
    logic [THR_W-1:0] rx_thr;
    logic             srst;
    logic             flush;
    logic             unit4;
  } cfg_t;
endpackage

// File: rtl/wfifo_cfg.sv
module wfifo_cfg
  import wfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output cfg_t              cfg,
  output logic [WORD_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.tx_thr <= wdata[CFG_TX_THR_LSB +: THR_W];
      cfg.rx_thr <= wdata[CFG_RX_THR_LSB +: THR_W];
      cfg.srst   <= wdata[CFG_SRST_BIT];
      cfg.flush  <= wdata[CFG_FLUSH_BIT];
      cfg.unit4  <= wdata[CFG_UNIT4_BIT];
    end else begin
      cfg.flush <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CFG_TX_THR_LSB +: THR_W] = cfg.tx_thr;
    rdata[CFG_RX_THR_LSB +: THR_W] = cfg.rx_thr;
    rdata[CFG_SRST_BIT]            = cfg.srst;
    rdata[CFG_FLUSH_BIT]           = cfg.flush;
    rdata[CFG_UNIT4_BIT]           = cfg.unit4;
  end

  // R11: flush bit drops by itself one clock after being set
  a_r11_flush_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.flush && !we) |=> !cfg.flush);
endmodule

// File: rtl/wfifo_core.sv
module wfifo_core
  import wfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter bit IS_RX = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              flush,
  input  logic              unit4,
  input  logic [THR_W-1:0]  thr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  input  logic              clr_ovf,
  input  logic              clr_udf,
  output logic              full,
  output logic              empty,
  output logic              level_ok,
  output logic              ovf,
  output logic              udf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [CW-1:0] unit_c;
  logic [PW-1:0] unit_p;
  logic [PW-1:0] wr_idx [UNIT_MAX];
  logic [PW-1:0] rd_idx [UNIT_MAX];
  logic          hold, push_go, pop_go;

  assign unit_c = unit4 ? CW'(UNIT_MAX) : CW'(1);
  assign unit_p = unit4 ? PW'(UNIT_MAX) : PW'(1);

  always_comb begin
    full  = (int'(count) + int'(unit_c)) > DEPTH;
    empty = int'(count) < int'(unit_c);
  end

  generate
    if (IS_RX) begin : g_rx_level
      assign level_ok = int'(count) > int'(thr);
    end else begin : g_tx_level
      assign level_ok = int'(count) <= int'(thr);
    end
  endgenerate

  assign hold      = srst || flush;
  assign push_go   = in_valid && !full && !hold;
  assign pop_go    = out_ready && !empty && !hold;
  assign in_ready  = !full;
  assign out_valid = !empty;

  generate
    for (genvar gi = 0; gi < UNIT_MAX; gi++) begin : g_lane
      assign wr_idx[gi] = wr_ptr + PW'(gi);
      assign rd_idx[gi] = rd_ptr + PW'(gi);
      if (gi == 0) begin : g_first
        assign out_data[8*gi +: 8] = mem[rd_idx[gi]];
      end else begin : g_upper
        assign out_data[8*gi +: 8] = unit4 ? mem[rd_idx[gi]] : 8'h00;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < UNIT_MAX; i++) begin
      if (push_go && (i == 0 || unit4)) mem[wr_idx[i]] <= in_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (hold) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_go) wr_ptr <= wr_ptr + unit_p;
      if (pop_go)  rd_ptr <= rd_ptr + unit_p;
      count <= count + (push_go ? unit_c : '0) - (pop_go ? unit_c : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else if (srst) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      ovf <= (ovf && !clr_ovf) || (in_valid && full && !flush);
      udf <= (udf && !clr_udf) || (out_ready && empty && !flush);
    end
  end

  // R4: occupancy never exceeds storage
  a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  // R6: a push into a full FIFO is flagged and does not change occupancy
  a_r6_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !hold) |=> ovf);
  a_r6_overflow_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !out_ready && !hold) |=> $stable(count));
  // R7: a pop from an empty FIFO is flagged
  a_r7_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && empty && !hold) |=> udf);
  // R11: flush empties the FIFO
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R12: soft reset clears storage and flags
  a_r12_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (count == '0 && !ovf && !udf));
endmodule

// File: rtl/spi_word_fifo_pair.sv
module spi_word_fifo_pair
  import wfifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [3:0]        err_clr,
  output logic [ST_W-1:0]   status,
  input  logic              bus_tx_valid,
  output logic              bus_tx_ready,
  input  logic [WORD_W-1:0] bus_tx_data,
  output logic              sh_tx_valid,
  input  logic              sh_tx_ready,
  output logic [WORD_W-1:0] sh_tx_data,
  input  logic              sh_rx_valid,
  output logic              sh_rx_ready,
  input  logic [WORD_W-1:0] sh_rx_data,
  output logic              bus_rx_valid,
  input  logic              bus_rx_ready,
  output logic [WORD_W-1:0] bus_rx_data
);
  cfg_t cfg;
  logic tx_full, tx_empty, tx_lvl, tx_ovf, tx_udf;
  logic rx_full, rx_empty, rx_lvl, rx_ovf, rx_udf;

  wfifo_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  wfifo_core #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n), .srst(cfg.srst), .flush(cfg.flush),
    .unit4(cfg.unit4), .thr(cfg.tx_thr),
    .in_valid(bus_tx_valid), .in_ready(bus_tx_ready), .in_data(bus_tx_data),
    .out_valid(sh_tx_valid), .out_ready(sh_tx_ready), .out_data(sh_tx_data),
    .clr_ovf(err_clr[ST_TX_OVF-8]), .clr_udf(err_clr[ST_TX_UDF-8]),
    .full(tx_full), .empty(tx_empty), .level_ok(tx_lvl),
    .ovf(tx_ovf), .udf(tx_udf)
  );

  wfifo_core #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n), .srst(cfg.srst), .flush(cfg.flush),
    .unit4(cfg.unit4), .thr(cfg.rx_thr),
    .in_valid(sh_rx_valid), .in_ready(sh_rx_ready), .in_data(sh_rx_data),
    .out_valid(bus_rx_valid), .out_ready(bus_rx_ready), .out_data(bus_rx_data),
    .clr_ovf(err_clr[ST_RX_OVF-8]), .clr_udf(err_clr[ST_RX_UDF-8]),
    .full(rx_full), .empty(rx_empty), .level_ok(rx_lvl),
    .ovf(rx_ovf), .udf(rx_udf)
  );

  always_comb begin
    status              = '0;
    status[ST_RX_RDY]   = rx_lvl;
    status[ST_TX_RDY]   = tx_lvl;
    status[ST_RX_EMPTY] = rx_empty;
    status[ST_RX_FULL]  = rx_full;
    status[ST_TX_EMPTY] = tx_empty;
    status[ST_TX_FULL]  = tx_full;
    status[ST_RX_UDF]   = rx_udf;
    status[ST_RX_OVF]   = rx_ovf;
    status[ST_TX_UDF]   = tx_udf;
    status[ST_TX_OVF]   = tx_ovf;
  end

  // R4: a full FIFO never offers input ready
  a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_TX_FULL] && bus_tx_ready));
  // R5: an empty FIFO never offers output valid
  a_r5_empty_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_RX_EMPTY] && bus_rx_valid));
endmodule

// File: tb/spi_word_fifo_pair_bench.sv
module spi_word_fifo_pair_bench;
  localparam int CLK_PERIOD = 8;
  localparam int DEPTH = 8;
  localparam logic [31:0] MASK = 32'h7701_0220;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [31:0] cfg_wdata = 0; logic [31:0] cfg_rdata;
  logic [3:0] err_clr = 0; logic [11:0] status;
  logic bus_tx_valid = 0, bus_tx_ready; logic [31:0] bus_tx_data = 0;
  logic sh_tx_valid, sh_tx_ready = 0; logic [31:0] sh_tx_data;
  logic sh_rx_valid = 0, sh_rx_ready; logic [31:0] sh_rx_data = 0;
  logic bus_rx_valid, bus_rx_ready = 0; logic [31:0] bus_rx_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_word_fifo_pair #(.DEPTH(DEPTH)) u_spi_word_fifo_pair (.*);

  // Reference model
  logic [7:0] txq[$], rxq[$];
  logic [3:0] merr;   // [0] rx udf, [1] rx ovf, [2] tx udf, [3] tx ovf
  logic [31:0] mcfg;

  function automatic logic [31:0] head(input logic [7:0] q[$], input int u);
    logic [31:0] w = 0;
    for (int i = 0; i < u; i++) if (i < q.size()) w[8*i +: 8] = q[i];
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); merr = 0; mcfg = 0;
    end else begin
      logic [3:0] set;
      int u, pre;
      set = 0;
      u = mcfg[5] ? 4 : 1;
      if (mcfg[16] || mcfg[9]) begin
        txq.delete(); rxq.delete();
      end else begin
        pre = txq.size();
        if (bus_tx_valid) begin
          if (pre > DEPTH - u) set[3] = 1;
          else for (int i = 0; i < u; i++) txq.push_back(bus_tx_data[8*i +: 8]);
        end
        if (sh_tx_ready) begin
          if (pre < u) set[2] = 1;
          else for (int i = 0; i < u; i++) void'(txq.pop_front());
        end
        pre = rxq.size();
        if (sh_rx_valid) begin
          if (pre > DEPTH - u) set[1] = 1;
          else for (int i = 0; i < u; i++) rxq.push_back(sh_rx_data[8*i +: 8]);
        end
        if (bus_rx_ready) begin
          if (pre < u) set[0] = 1;
          else for (int i = 0; i < u; i++) void'(rxq.pop_front());
        end
      end
      if (mcfg[16]) merr = 0;
      else merr = (merr & ~err_clr) | set;
      if (cfg_we) mcfg = cfg_wdata & MASK;
      else mcfg[9] = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison, half a period after the updating edge
  always @(negedge clk) begin
    if (rst_n) begin
      int u;
      bit txf, txe, rxf, rxe;
      u = mcfg[5] ? 4 : 1;
      txf = txq.size() > DEPTH - u; txe = txq.size() < u;
      rxf = rxq.size() > DEPTH - u; rxe = rxq.size() < u;
      chk("R13", "cfg readback", cfg_rdata, mcfg);
      chk("R4", "tx full/ready", {status[7], bus_tx_ready}, {txf, !txf});
      chk("R4", "rx full/ready", {status[5], sh_rx_ready}, {rxf, !rxf});
      chk("R5", "tx empty/valid", {status[6], sh_tx_valid}, {txe, !txe});
      chk("R5", "rx empty/valid", {status[4], bus_rx_valid}, {rxe, !rxe});
      chk("R9", "tx ready flag", status[3], txq.size() <= int'(mcfg[30:28]));
      chk("R10", "rx ready flag", status[2], rxq.size() > int'(mcfg[26:24]));
      chk("R6", "overflow flags", {status[11], status[9]}, {merr[3], merr[1]});
      chk("R7", "underflow flags", {status[10], status[8]}, {merr[2], merr[0]});
      chk("R1", "unused status bits", status[1:0], 2'b00);
      if (!txe) chk(mcfg[5] ? "R2" : "R3", "tx data", sh_tx_data, head(txq, u));
      if (!rxe) chk(mcfg[5] ? "R2" : "R3", "rx data", bus_rx_data, head(rxq, u));
    end
  end

  task automatic wr_cfg(input logic [31:0] v);
    cfg_we = 1; cfg_wdata = v; @(negedge clk); cfg_we = 0;
  endtask
  task automatic push_tx(input logic [31:0] d);
    bus_tx_valid = 1; bus_tx_data = d; @(negedge clk); bus_tx_valid = 0;
  endtask
  task automatic pop_tx();
    sh_tx_ready = 1; @(negedge clk); sh_tx_ready = 0;
  endtask
  task automatic push_rx(input logic [31:0] d);
    sh_rx_valid = 1; sh_rx_data = d; @(negedge clk); sh_rx_valid = 0;
  endtask
  task automatic pop_rx();
    bus_rx_ready = 1; @(negedge clk); bus_rx_ready = 0;
  endtask
  task automatic clr(input logic [3:0] m);
    err_clr = m; @(negedge clk); err_clr = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", "status after reset", status, 12'h058);
    chk("R1", "cfg after reset", cfg_rdata, 32'h0);
    @(negedge clk);

    // R2: 4-byte units, little-endian, then overflow and underflow
    wr_cfg(32'h3300_0020);
    push_tx(32'h4433_2211);
    chk("R2", "first tx unit", sh_tx_data, 32'h4433_2211);
    push_tx(32'h8877_6655);
    push_tx(32'hDEAD_BEEF);
    chk("R6", "tx overflow sticky", status[11], 1'b1);
    pop_tx();
    chk("R2", "second tx unit", sh_tx_data, 32'h8877_6655);
    pop_tx(); pop_tx();
    chk("R7", "tx underflow sticky", status[10], 1'b1);
    @(negedge clk);
    chk("R6", "tx overflow held", status[11], 1'b1);
    clr(4'b1100);
    chk("R8", "tx errors cleared", status[11:10], 2'b00);

    push_rx(32'hA1A2_A3A4); push_rx(32'hB1B2_B3B4); push_rx(32'hC1C2_C3C4);
    chk("R6", "rx overflow", status[9], 1'b1);
    pop_rx(); pop_rx(); pop_rx();
    chk("R7", "rx underflow", status[8], 1'b1);
    // R8: set wins over clear in the same cycle
    bus_rx_ready = 1; err_clr = 4'b0001; @(negedge clk); bus_rx_ready = 0; err_clr = 0;
    chk("R8", "set beats clear", status[8], 1'b1);
    clr(4'b0011);

    // R3 and R13: 1-byte units
    wr_cfg(32'h6000_0000);
    for (int i = 0; i < 9; i++) push_tx(32'hFFFF_FF00 | i);
    chk("R3", "byte unit output", sh_tx_data, 32'h0000_0000);
    pop_tx(); pop_tx();
    chk("R3", "third byte", sh_tx_data, 32'h0000_0002);
    push_rx(32'h1234_5677); push_rx(32'h0000_0088);

    // R11: flush
    wr_cfg(32'h6000_0200);
    chk("R11", "flush bit set", cfg_rdata[9], 1'b1);
    @(negedge clk);
    chk("R11", "flush bit self-cleared", cfg_rdata[9], 1'b0);
    chk("R11", "both empty after flush", {status[6], status[4]}, 2'b11);
    chk("R11", "errors kept", status[11], 1'b1);

    // R12: soft reset
    wr_cfg(32'h6001_0000);
    push_tx(32'h55); push_rx(32'h66);
    chk("R12", "status under soft reset", status, 12'h058);
    wr_cfg(32'h6000_0000);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bus_tx_valid = ($urandom % 3) == 0;
      bus_tx_data  = $urandom;
      sh_tx_ready  = ($urandom % 3) == 0;
      sh_rx_valid  = ($urandom % 3) == 0;
      sh_rx_data   = $urandom;
      bus_rx_ready = ($urandom % 3) == 0;
      err_clr      = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      cfg_we       = ($urandom % 40) == 0;
      cfg_wdata    = $urandom & 32'h7700_0020;
      if (($urandom % 5) == 0) cfg_wdata[9] = 1'b1;
      if (($urandom % 9) == 0) cfg_wdata[16] = 1'b1;
      @(negedge clk);
    end
    bus_tx_valid = 0; sh_tx_ready = 0; sh_rx_valid = 0; bus_rx_ready = 0;
    err_clr = 0; cfg_we = 0;
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule